// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. In a single combinational pass it fetches the word at the program counter, decodes it, reads two source registers, runs the ALU, accesses data memory, and picks the next program counter. The register file, the data memory and the program counter all update together on the following edge. The core has no pipeline registers, so it needs no forwarding and never stalls.

The instruction set has nine operations. Five are register-register ALU operations: add, subtract, and, or and exclusive-or. The others are a word load, a word store, branch-if-equal and an unconditional jump. A preload port fills the instruction memory or the data memory while the core is held in reset. Two combinational debug ports read any register and any data-memory word, and the program counter is visible at all times. A program is run by holding reset, writing its code and data through the preload port, and then releasing reset.

The core has no control state machine. Its only sequential state is the program counter register, the register file and the two word-addressed memories. Every instruction uses the same path from fetch to write-back.

Top module: `scp_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the program counter to 0 and clears registers 1 to 31 to 0. Data-memory contents are kept across reset.
- R2: Opcode bits [31:26] = 0x00 selects a register-register operation, chosen by bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor. The result of rs (bits [25:21]) op rt (bits [20:16]) is written to rd (bits [15:11]), with 32-bit wraparound.
- R3: Opcode 0x23 loads a word. It writes data-memory word ((rs + sign-extended bits [15:0]) >> 2) modulo the memory depth into rt within the same instruction's cycle.
- R4: Opcode 0x2B stores the value of rt at the word selected as in R3. Address bits [1:0] are ignored, and no register changes.
- R5: Register 0 always reads as 0, and writes to it have no effect.
- R6: Opcode 0x04 compares rs with rt by subtraction. When the two are equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4. No register or memory write takes place.
- R7: Opcode 0x02 sets the program counter to {PC+4 bits [31:28], instruction bits [25:0], 2'b00}, with no register or memory write.
- R8: Every instruction other than a taken branch or a jump advances the program counter by exactly 4 on the next edge. Instruction word (PC >> 2) modulo the memory depth is executed.
- R9: Any opcode not listed above, and opcode 0x00 with a function code not listed in R2, acts as a no-op. It writes nothing, and the program counter advances by 4.
- R10: While load_en is high, load_data is written on the clock edge to instruction word load_addr (load_to_data = 0) or to data word load_addr (load_to_data = 1). The debug ports return the register or data word they select combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Preload write strobe |
| load_to_data | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | LOAD_AW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DMEM_AW | Data-memory word index for the debug read |
| dbg_mem_val | output | 32 | Value of the selected data word |
| pc | output | 32 | Current program counter |

## Verification
The core's state consists of the program counter, the registers and the data words, and all of it is visible at the ports. A wrong next-PC choice therefore shows on the pc port one edge after the faulty instruction. A wrong ALU result, write-back select or destination choice shows on the register debug port in the cycle after the write. A mis-addressed store shows on the memory debug port at the same edge. Errors also propagate: a corrupted register changes later load addresses and branch outcomes, so the program counter trace diverges within a few instructions.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int REG_AW = $clog2(NREGS);

    localparam logic [5:0] OPC_REGREG = 6'h00;
    localparam logic [5:0] OPC_LOADW  = 6'h23;
    localparam logic [5:0] OPC_STOREW = 6'h2B;
    localparam logic [5:0] OPC_BREQ   = 6'h04;
    localparam logic [5:0] OPC_JUMP   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    alu_src;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;
        logic    branch;
        logic    jump;
        logic    reg_dst;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
    import scp_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_REGREG: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LOADW: begin
                ctrl.reg_write  = 1'b1;
                ctrl.alu_src    = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STOREW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BREQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
    import scp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [0:N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/scp_ram.sv
module scp_ram #(
    parameter int DEPTH = 64,
    parameter int W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IMEM_AW = $clog2(IMEM_WORDS),
    localparam int DMEM_AW = $clog2(DMEM_WORDS),
    localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic               load_to_data,
    input  logic [LOAD_AW-1:0] load_addr,
    input  logic [XLEN-1:0]    load_data,
    input  logic [REG_AW-1:0]  dbg_reg_sel,
    output logic [XLEN-1:0]    dbg_reg_val,
    input  logic [DMEM_AW-1:0] dbg_mem_sel,
    output logic [XLEN-1:0]    dbg_mem_val,
    output logic [XLEN-1:0]    pc
);

    logic [XLEN-1:0]    pc_q;
    logic [XLEN-1:0]    pc_next;
    logic [XLEN-1:0]    pc_plus4;
    logic [XLEN-1:0]    br_tgt;
    logic [XLEN-1:0]    j_tgt;
    logic [XLEN-1:0]    instr;
    ctrl_t              ctrl;
    logic [XLEN-1:0]    simm;
    logic [XLEN-1:0]    rs_val;
    logic [XLEN-1:0]    rt_val;
    logic [XLEN-1:0]    alu_b;
    logic [XLEN-1:0]    alu_y;
    logic               alu_zero;
    logic [XLEN-1:0]    dmem_rd;
    logic [XLEN-1:0]    load_val;
    logic [XLEN-1:0]    wb_val;
    logic [REG_AW-1:0]  wb_addr;
    logic               wb_en;
    logic               dmem_we;
    logic [DMEM_AW-1:0] dmem_waddr;
    logic [XLEN-1:0]    dmem_wdata;
    logic               imem_we;

    // Fetch
    assign imem_we = load_en && !load_to_data;

    scp_ram #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk     (clk),
        .we      (imem_we),
        .waddr   (load_addr[IMEM_AW-1:0]),
        .wdata   (load_data),
        .raddr_a (pc_q[IMEM_AW+1:2]),
        .rdata_a (instr),
        .raddr_b (pc_q[IMEM_AW+1:2]),
        .rdata_b ()
    );

    // Decode
    scp_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign simm    = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign wb_addr = ctrl.reg_dst ? instr[15:11] : instr[20:16];
    assign wb_en   = ctrl.reg_write && !rst;

    // Registers
    scp_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .ra3 (dbg_reg_sel),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .rd3 (dbg_reg_val),
        .we  (wb_en),
        .wa  (wb_addr),
        .wd  (wb_val)
    );

    // Execute
    assign alu_b = ctrl.alu_src ? simm : rt_val;

    scp_alu #(.W(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory: preload has priority over a store
    always_comb begin
        if (load_en && load_to_data) begin
            dmem_we    = 1'b1;
            dmem_waddr = load_addr[DMEM_AW-1:0];
            dmem_wdata = load_data;
        end else begin
            dmem_we    = ctrl.mem_write && !rst;
            dmem_waddr = alu_y[DMEM_AW+1:2];
            dmem_wdata = rt_val;
        end
    end

    scp_ram #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk     (clk),
        .we      (dmem_we),
        .waddr   (dmem_waddr),
        .wdata   (dmem_wdata),
        .raddr_a (alu_y[DMEM_AW+1:2]),
        .rdata_a (dmem_rd),
        .raddr_b (dbg_mem_sel),
        .rdata_b (dbg_mem_val)
    );

    // Write-back
    assign load_val = ctrl.mem_read ? dmem_rd : '0;
    assign wb_val   = ctrl.mem_to_reg ? load_val : alu_y;

    // Next program counter
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {simm[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        pc_next = pc_plus4;
        if (ctrl.jump)
            pc_next = j_tgt;
        else if (ctrl.branch && alu_zero)
            pc_next = br_tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc = pc_q;

endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [4:0]  dbg_reg_sel,
    input logic [31:0] dbg_reg_val
);

    logic [5:0]  op;
    logic [31:0] seq_pc;
    logic [31:0] exp_br;
    logic [31:0] exp_j;

    assign op     = instr[31:26];
    assign seq_pc = pc + 32'd4;
    assign exp_br = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign exp_j  = {seq_pc[31:28], instr[25:0], 2'b00};

    // R5: register 0 reads as zero
    a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == 5'd0) |-> (dbg_reg_val == 32'd0));

    // R8, R9: sequential advance
    a_r8_seq_advance: assert property (@(posedge clk) disable iff (rst)
        ((op != 6'h04) && (op != 6'h02)) |=> (pc == $past(seq_pc)));

    // R6: taken branch
    a_r6_beq_taken: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'h04) && (rs_val == rt_val)) |=> (pc == $past(exp_br)));

    // R6: branch not taken
    a_r6_beq_fall: assert property (@(posedge clk) disable iff (rst)
        ((op == 6'h04) && (rs_val != rt_val)) |=> (pc == $past(seq_pc)));

    // R7: jump target
    a_r7_jump: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h02) |=> (pc == $past(exp_j)));

endmodule

bind scp_core scp_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc          (pc_q),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .dbg_reg_sel (dbg_reg_sel),
    .dbg_reg_val (dbg_reg_val)
);

// File: tb/tb_scp_core.sv
`timescale 1ns/1ps
module tb_scp_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_to_data = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [5:0]  dbg_mem_sel = '0;
    logic [31:0] dbg_mem_val;
    logic [31:0] pc;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_imem [0:63];
    logic [31:0] m_mem  [0:63];
    logic [31:0] m_reg  [0:31];
    logic [31:0] m_pc;
    string       m_tag;

    always #4 clk = ~clk;   // 125 MHz

    scp_core dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_to_data(load_to_data),
        .load_addr(load_addr), .load_data(load_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val), .pc(pc)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_rr(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    task automatic model_step();
        logic [31:0] ins, a, b, res, simm, addr, npc;
        logic        ok;
        ins  = m_imem[m_pc[7:2]];
        a    = m_reg[ins[25:21]];
        b    = m_reg[ins[20:16]];
        simm = {{16{ins[15]}}, ins[15:0]};
        addr = a + simm;
        npc  = m_pc + 4;
        m_tag = "R8";
        case (ins[31:26])
            6'h00: begin
                ok = 1'b1;
                res = 32'd0;
                case (ins[5:0])
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h26: res = a ^ b;
                    default: begin ok = 1'b0; m_tag = "R9"; end
                endcase
                if (ok && ins[15:11] != 0) m_reg[ins[15:11]] = res;
            end
            6'h23: if (ins[20:16] != 0) m_reg[ins[20:16]] = m_mem[addr[7:2]];
            6'h2B: m_mem[addr[7:2]] = b;
            6'h04: begin
                m_tag = "R6";
                if (a == b) npc = npc + {simm[29:0], 2'b00};
            end
            6'h02: begin
                m_tag = "R7";
                npc = {npc[31:28], ins[25:0], 2'b00};
            end
            default: m_tag = "R9";
        endcase
        m_pc = npc;
    endtask

    task automatic model_reset();
        m_pc = 0;
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
    endtask

    task automatic preload(bit to_data, int idx, logic [31:0] val);
        @(negedge clk);
        load_en = 1'b1; load_to_data = to_data;
        load_addr = idx[5:0]; load_data = val;
        if (to_data) m_mem[idx] = val; else m_imem[idx] = val;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            dbg_reg_sel = c[4:0];
            dbg_mem_sel = c[5:0];
            #1;
            check(m_tag, "pc", pc, m_pc);
            check("R2", "reg sample", dbg_reg_val, m_reg[c[4:0]]);
            check("R4", "mem sample", dbg_mem_val, m_mem[c[5:0]]);
        end
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 32; i++) begin
            dbg_reg_sel = i[4:0]; #1;
            check(tag, $sformatf("reg %0d", i), dbg_reg_val, m_reg[i]);
        end
        for (int i = 0; i < 64; i++) begin
            dbg_mem_sel = i[5:0]; #1;
            check(tag, $sformatf("mem %0d", i), dbg_mem_val, m_mem[i]);
        end
    endtask

    task automatic peek_reg(string tag, int r, logic [31:0] exp);
        dbg_reg_sel = r[4:0]; #1;
        check(tag, $sformatf("reg %0d", r), dbg_reg_val, exp);
    endtask

    task automatic peek_mem(string tag, int w, logic [31:0] exp);
        dbg_mem_sel = w[5:0]; #1;
        check(tag, $sformatf("mem %0d", w), dbg_mem_val, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_imem[i] = 32'hFC00_0000; m_mem[i] = 0; end
        model_reset();
        repeat (3) @(posedge clk);
        // Fill both memories with known values first
        for (int i = 0; i < 64; i++) preload(1'b0, i, 32'hFC00_0000);
        for (int i = 0; i < 64; i++) preload(1'b1, i, 32'd0);
        @(negedge clk); #1;
        check("R1", "pc in reset", pc, 32'd0);
        peek_reg("R1", 7, 32'd0);

        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'd7);
        preload(1'b1, 2, 32'hFFFF_FFFF);
        preload(1'b1, 3, 32'h8000_0000);
        preload(1'b0, 0,  enc_i(6'h23, 5'd1, 5'd0, 16'd0));
        preload(1'b0, 1,  enc_i(6'h23, 5'd2, 5'd0, 16'd4));
        preload(1'b0, 2,  enc_i(6'h23, 5'd3, 5'd0, 16'd8));
        preload(1'b0, 3,  enc_i(6'h23, 5'd4, 5'd0, 16'd12));
        preload(1'b0, 4,  enc_rr(6'h20, 5'd5, 5'd1, 5'd2));
        preload(1'b0, 5,  enc_rr(6'h22, 5'd6, 5'd1, 5'd2));
        preload(1'b0, 6,  enc_rr(6'h24, 5'd7, 5'd3, 5'd2));
        preload(1'b0, 7,  enc_rr(6'h25, 5'd8, 5'd1, 5'd4));
        preload(1'b0, 8,  enc_rr(6'h26, 5'd9, 5'd3, 5'd1));
        preload(1'b0, 9,  enc_rr(6'h20, 5'd10, 5'd4, 5'd4));
        preload(1'b0, 10, enc_rr(6'h20, 5'd0, 5'd1, 5'd2));
        preload(1'b0, 11, enc_i(6'h2B, 5'd5, 5'd0, 16'd16));
        preload(1'b0, 12, enc_i(6'h2B, 5'd6, 5'd0, 16'd21));
        preload(1'b0, 13, enc_i(6'h23, 5'd11, 5'd0, 16'd23));
        preload(1'b0, 14, enc_i(6'h04, 5'd2, 5'd1, 16'd5));
        preload(1'b0, 15, enc_i(6'h04, 5'd1, 5'd1, 16'd2));
        preload(1'b0, 16, enc_rr(6'h20, 5'd12, 5'd1, 5'd1));
        preload(1'b0, 17, enc_rr(6'h20, 5'd12, 5'd1, 5'd1));
        preload(1'b0, 18, enc_j(26'd22));
        preload(1'b0, 19, enc_rr(6'h20, 5'd13, 5'd1, 5'd1));
        preload(1'b0, 20, enc_rr(6'h20, 5'd13, 5'd1, 5'd1));
        preload(1'b0, 21, enc_rr(6'h20, 5'd13, 5'd1, 5'd1));
        preload(1'b0, 22, {6'h3F, 5'd0, 5'd1, 16'd0});
        preload(1'b0, 23, enc_rr(6'h21, 5'd14, 5'd1, 5'd2));
        preload(1'b0, 24, enc_i(6'h23, 5'd15, 5'd5, 16'hFFFC));
        preload(1'b0, 25, enc_i(6'h2B, 5'd15, 5'd0, 16'd0));
        preload(1'b0, 26, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));

        @(negedge clk); #1;
        peek_mem("R10", 2, 32'hFFFF_FFFF);
        peek_mem("R10", 3, 32'h8000_0000);

        @(negedge clk);
        rst = 1'b0;
        run(40);

        peek_reg("R2", 5, 32'd12);
        peek_reg("R2", 6, 32'hFFFF_FFFE);
        peek_reg("R2", 7, 32'd7);
        peek_reg("R2", 8, 32'h8000_0005);
        peek_reg("R2", 9, 32'hFFFF_FFFA);
        peek_reg("R2", 10, 32'd0);
        peek_reg("R5", 0, 32'd0);
        peek_reg("R3", 11, 32'hFFFF_FFFE);
        peek_reg("R3", 15, 32'hFFFF_FFFF);
        peek_mem("R4", 4, 32'd12);
        peek_mem("R4", 5, 32'hFFFF_FFFE);
        peek_reg("R6", 12, 32'd0);
        peek_reg("R7", 13, 32'd0);
        peek_reg("R9", 14, 32'd0);
        peek_reg("R9", 1, 32'd5);
        check("R6", "halt pc", pc, 32'd104);
        sweep("R2");

        // Second pass: reset mid-run, memory kept, new data pattern
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk); #1;
        check("R1", "pc after reset", pc, 32'd0);
        peek_reg("R1", 5, 32'd0);
        peek_mem("R1", 0, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b0;
        run(40);
        peek_reg("R2", 5, 32'd6);
        peek_reg("R3", 15, 32'hFFFF_FFFF);
        sweep("R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule